// File: doc/BRIEF.md
# FM Operator Gate Decoder

This block sits behind the register port of a six-channel, four-operator FM synthesizer. It watches writes to the operator gate control register. Each written byte carries a channel code in its low three bits and four operator gate bits in its high nibble. The block keeps the current gate nibble of every channel and compares each new nibble with the stored one. For every operator whose gate changed, it issues a single-cycle start pulse or stop pulse to the envelope logic of that operator slot.

One channel can also be gated by a timer-driven composite-sine mode. A separate four-bit input supplies that mode's forced gates. The block registers this input and ORs it into both the old and the new nibble of that channel before comparing them. An operator held by the forced gate therefore produces no edge when software changes its bit.

Control is a two-state machine. `FMK_IDLE` is the quiet state. `FMK_EMIT` is the state in which the registered pulse vectors are driven out. The transitions are as follows:
- go-emit: `FMK_IDLE` to `FMK_EMIT` on a write with a valid code.
- re-emit: `FMK_EMIT` to `FMK_EMIT` on another valid write in the very next cycle.
- drop: `FMK_EMIT` to `FMK_IDLE` when no valid write arrives.
- hold: `FMK_IDLE` stays in `FMK_IDLE` when no valid write arrives.

Top module: `fmk_keyon_dec`

## Requirements
- R1: While reset is asserted, and after it is released, all stored gate bits, the registered forced-gate copy and both pulse vectors are zero.
- R2: A write whose code `wr_data[2:0]` is 3 or 7 changes no stored gate bit and produces no pulse.
- R3: Codes 0, 1 and 2 select channels 0, 1 and 2. Codes 4, 5 and 6 select channels 3, 4 and 5. Channel c owns the operator slots 4c to 4c+3, and the pulses of one write appear only within those four slots.
- R4: A valid write replaces the selected channel's stored nibble with `wr_data[7:4]`, where bit 4 is operator 0 and bit 7 is operator 3 (slot 4c+k for bit 4+k). The stored state changes at no other time. Bit 3 has no effect.
- R5: An operator whose effective gate goes from 0 to 1 pulses `key_on` in its slot. The pulse is high for exactly the one cycle after the clock edge that accepted the write.
- R6: An operator whose effective gate goes from 1 to 0 pulses `key_off` in its slot for exactly that same cycle.
- R7: Rewriting a channel with the gate bits it already holds produces no pulse.
- R8: For channel 2, the forced-gate vector, sampled one clock earlier, is ORed into both the old and the new nibble before the comparison. An operator whose forced bit is 1 never pulses, although its stored bit still follows the write.
- R9: The forced-gate vector has no effect on writes to any channel other than 2.
- R10: Without a valid write on the previous edge, both pulse vectors are zero.
- R11: `key_on` and `key_off` are never high in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the gate control register |
| wr_data | input | 8 | Written byte: [2:0] channel code, [7:4] operator gates |
| csm_keyon | input | 4 | Forced operator gates of the timer-driven mode (channel 2) |
| key_on | output | 24 | One-cycle start pulse per operator slot |
| key_off | output | 24 | One-cycle stop pulse per operator slot |
| gate_state | output | 24 | Stored gate bit per operator slot |

## Verification
The bench sends writes that carry the two dead codes, 3 and 7, after gates have been set. A design that decoded them would overwrite a neighbour channel or emit stray edges. It walks every valid code to catch an off-by-one remap, which would pulse the wrong group of four slots. It rewrites identical nibbles, where a design that compared against the wrong source would pulse again. It drives channel 2 with forced gates both set and clear, and the same vector against other channels. A design that applied the mask one-sided, or to every channel, would emit or lose edges in those cases. Random bytes and random forced vectors fill the gaps, with idle cycles in between to catch pulses that last longer than one cycle.

// File: rtl/fmk_pkg.sv
package fmk_pkg;

    localparam int FMK_CHANNELS = 6;
    localparam int FMK_OPS      = 4;
    localparam int FMK_SLOTS    = FMK_CHANNELS * FMK_OPS;
    localparam int FMK_CODE_W   = 3;
    localparam int FMK_DATA_W   = 8;

    typedef enum logic [0:0] {
        FMK_IDLE = 1'b0,
        FMK_EMIT = 1'b1
    } fmk_state_e;

    typedef struct packed {
        logic                  valid;
        logic [FMK_CODE_W-1:0] chan;
    } fmk_sel_t;

endpackage

// File: rtl/fmk_code_map.sv
// Turns the 3-bit channel code into a channel index; two codes are dead.
module fmk_code_map
    import fmk_pkg::*;
(
    input  logic [FMK_CODE_W-1:0] code,
    output fmk_sel_t              sel
);

    always_comb begin
        sel.valid = 1'b1;
        sel.chan  = code;
        unique case (code)
            3'd3, 3'd7: begin
                sel.valid = 1'b0;
                sel.chan  = '0;
            end
            3'd4, 3'd5, 3'd6: sel.chan = code - 3'd1;
            default:          sel.chan = code;
        endcase
    end

endmodule

// File: rtl/fmk_change_calc.sv
// Edge finder for one channel nibble with a forced-gate overlay.
module fmk_change_calc #(
    parameter int OPS = 4
) (
    input  logic [OPS-1:0] new_gate,
    input  logic [OPS-1:0] old_gate,
    input  logic [OPS-1:0] force_mask,
    output logic [OPS-1:0] rise,
    output logic [OPS-1:0] fall
);

    logic [OPS-1:0] eff_new;
    logic [OPS-1:0] eff_old;
    logic [OPS-1:0] moved;

    always_comb begin
        eff_new = new_gate | force_mask;
        eff_old = old_gate | force_mask;
        moved   = eff_new ^ eff_old;
        rise    = moved & new_gate;
        fall    = moved & ~new_gate;
    end

endmodule

// File: rtl/fmk_gate_bank.sv
// Per-channel storage of operator gate nibbles.
module fmk_gate_bank #(
    parameter int CHANNELS = 6,
    parameter int OPS      = 4,
    parameter int SEL_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [SEL_W-1:0]        chan,
    input  logic [OPS-1:0]          nibble,
    output logic [CHANNELS*OPS-1:0] gates
);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        logic [OPS-1:0] nib_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q <= '0;
            end else if (load && (chan == SEL_W'(c))) begin
                nib_q <= nibble;
            end
        end
        assign gates[c*OPS +: OPS] = nib_q;
    end

endmodule

// File: rtl/fmk_keyon_dec.sv
// Operator gate decoder: stores gates, emits one-cycle start/stop pulses.
module fmk_keyon_dec
    import fmk_pkg::*;
#(
    parameter int CSM_CHANNEL = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [FMK_DATA_W-1:0] wr_data,
    input  logic [FMK_OPS-1:0]    csm_keyon,
    output logic [FMK_SLOTS-1:0]  key_on,
    output logic [FMK_SLOTS-1:0]  key_off,
    output logic [FMK_SLOTS-1:0]  gate_state
);

    localparam int CH    = FMK_CHANNELS;
    localparam int OPS   = FMK_OPS;
    localparam int SLOTS = CH * OPS;
    localparam int NIB_LO = FMK_DATA_W - OPS;

    fmk_sel_t       sel;
    logic           write_ok;
    logic [OPS-1:0] new_nib;
    logic [OPS-1:0] old_nib;
    logic [OPS-1:0] csm_q;
    logic [OPS-1:0] csm_mask;
    logic [OPS-1:0] rise;
    logic [OPS-1:0] fall;
    logic [SLOTS-1:0] on_next;
    logic [SLOTS-1:0] off_next;
    logic [SLOTS-1:0] on_q;
    logic [SLOTS-1:0] off_q;
    logic           spare_unused;
    fmk_state_e     state_q;
    fmk_state_e     state_d;

    assign new_nib      = wr_data[FMK_DATA_W-1:NIB_LO];
    assign spare_unused = wr_data[FMK_CODE_W];

    fmk_code_map u_map (
        .code (wr_data[FMK_CODE_W-1:0]),
        .sel  (sel)
    );

    assign write_ok = wr_en && sel.valid;

    // Registered copy of the forced gates; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csm_q <= '0;
        end else begin
            csm_q <= csm_keyon;
        end
    end

    always_comb begin
        old_nib = '0;
        for (int c = 0; c < CH; c++) begin
            if (sel.chan == FMK_CODE_W'(c)) begin
                old_nib = gate_state[c*OPS +: OPS];
            end
        end
    end

    assign csm_mask = (sel.chan == FMK_CODE_W'(CSM_CHANNEL)) ? csm_q : '0;

    fmk_change_calc #(
        .OPS (OPS)
    ) u_calc (
        .new_gate   (new_nib),
        .old_gate   (old_nib),
        .force_mask (csm_mask),
        .rise       (rise),
        .fall       (fall)
    );

    for (genvar c = 0; c < CH; c++) begin : g_spread
        assign on_next[c*OPS +: OPS]  = (sel.chan == FMK_CODE_W'(c)) ? rise : '0;
        assign off_next[c*OPS +: OPS] = (sel.chan == FMK_CODE_W'(c)) ? fall : '0;
    end

    fmk_gate_bank #(
        .CHANNELS (CH),
        .OPS      (OPS),
        .SEL_W    (FMK_CODE_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (write_ok),
        .chan   (sel.chan),
        .nibble (new_nib),
        .gates  (gate_state)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FMK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: go-emit, re-emit, drop, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FMK_IDLE: state_d = write_ok ? FMK_EMIT : FMK_IDLE;
            FMK_EMIT: state_d = write_ok ? FMK_EMIT : FMK_IDLE;
            default:  state_d = FMK_IDLE;
        endcase
    end

    // Outputs: pulse vectors captured on a valid write, shown in FMK_EMIT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q  <= '0;
            off_q <= '0;
        end else if (write_ok) begin
            on_q  <= on_next;
            off_q <= off_next;
        end
    end

    assign key_on  = (state_q == FMK_EMIT) ? on_q  : '0;
    assign key_off = (state_q == FMK_EMIT) ? off_q : '0;

endmodule

// File: rtl/fmk_keyon_dec_chk.sv
module fmk_keyon_dec_chk #(
    parameter int CH  = 6,
    parameter int OPS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [CH*OPS-1:0] gate,
    input logic [CH*OPS-1:0] key_on,
    input logic [CH*OPS-1:0] key_off
);

    logic [CH-1:0] grp_active;
    for (genvar c = 0; c < CH; c++) begin : g_grp
        assign grp_active[c] = |(key_on[c*OPS +: OPS] | key_off[c*OPS +: OPS]);
    end

    AST_EXCLUSIVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on & key_off) == '0); // R11

    AST_ON_LEAVES_GATE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on & ~gate) == '0); // R5

    AST_OFF_LEAVES_GATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (key_off & gate) == '0); // R6

    AST_QUIET_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (key_on | key_off) == '0); // R10

    AST_DEAD_CODE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1:0] == 2'b11) |=> ($stable(gate) && (key_on | key_off) == '0)); // R2

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(gate)); // R4

    AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grp_active) <= 1); // R3

endmodule

bind fmk_keyon_dec fmk_keyon_dec_chk #(
    .CH  (fmk_pkg::FMK_CHANNELS),
    .OPS (fmk_pkg::FMK_OPS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .gate    (gate_state),
    .key_on  (key_on),
    .key_off (key_off)
);

// File: tb/fmk_keyon_dec_bench.sv
`timescale 1ns/1ps
module fmk_keyon_dec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  csm_keyon = '0;
    logic [23:0] key_on;
    logic [23:0] key_off;
    logic [23:0] gate_state;

    int checks = 0;
    int errors = 0;
    logic [23:0] g_m = '0;
    logic [3:0]  csm_m = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fmk_keyon_dec u_fmk_keyon_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .csm_keyon  (csm_keyon),
        .key_on     (key_on),
        .key_off    (key_off),
        .gate_state (gate_state)
    );

    // Returns {next gates, start pulses, stop pulses} from R2..R9
    function automatic logic [71:0] predict(input logic [23:0] g,
                                            input logic [3:0] f,
                                            input logic [7:0] d);
        logic [23:0] gn = g;
        logic [23:0] on = '0;
        logic [23:0] off = '0;
        int code = int'(d[2:0]);
        int ch;
        logic [3:0] nn, on4, mv, fm;
        if (code != 3 && code != 7) begin
            ch  = (code > 3) ? code - 1 : code;
            nn  = d[7:4];
            on4 = g[ch*4 +: 4];
            fm  = (ch == 2) ? f : 4'h0;
            mv  = (nn | fm) ^ (on4 | fm);
            on[ch*4 +: 4]  = mv & nn;
            off[ch*4 +: 4] = mv & ~nn;
            gn[ch*4 +: 4]  = nn;
        end
        return {gn, on, off};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d, input string tag);
        logic [71:0] p;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        p = predict(g_m, csm_m, d);
        @(negedge clk);
        wr_en = 1'b0;
        chk(tag, "gate_state", gate_state, p[71:48]);
        chk(tag, "key_on",     key_on,     p[47:24]);
        chk(tag, "key_off",    key_off,    p[23:0]);
        chk("R11", "on&off",   key_on & key_off, 24'h0);
        g_m = p[71:48];
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R10", "idle key_on",  key_on,  24'h0);
        chk("R10", "idle key_off", key_off, 24'h0);
        chk("R4",  "idle gates",   gate_state, g_m);
    endtask

    task automatic set_csm(input logic [3:0] v);
        @(negedge clk);
        csm_keyon = v;
        @(negedge clk);
        csm_m = v;
    endtask

    function automatic string tag_for(input logic [7:0] d);
        if (d[2:0] == 3'd3 || d[2:0] == 3'd7) return "R2";
        if (d[2:0] == 3'd2 && csm_m != 4'h0) return "R8";
        if (csm_m != 4'h0) return "R9";
        return "R5";
    endfunction

    initial begin
        void'($urandom(32'h0F3A_2612));
        repeat (3) @(negedge clk);
        chk("R1", "reset gates",   gate_state, 24'h0);
        chk("R1", "reset key_on",  key_on,     24'h0);
        chk("R1", "reset key_off", key_off,    24'h0);
        rst_n = 1'b1;
        idle_cycle();

        // R3: every valid code lands in its own four slots
        for (int k = 0; k < 8; k++) do_write({4'h1 << (k % 4), 1'b0, 3'(k)}, "R3");
        // R2: dead codes after gates are set
        do_write(8'hF3, "R2");
        do_write(8'hA7, "R2");
        // R7: same value again
        do_write(8'h41, "R7");
        do_write(8'h41, "R7");
        // R6: clear everything on channel 5 (code 6)
        do_write(8'hF6, "R5");
        do_write(8'h06, "R6");
        // R4: bit 3 ignored
        do_write(8'h98, "R4");
        // R8: forced gates on channel 2
        set_csm(4'b0011);
        do_write(8'hF2, "R8");
        do_write(8'h02, "R8");
        // R9: same forced vector, other channels
        do_write(8'hF1, "R9");
        do_write(8'h35, "R9");
        set_csm(4'h0);
        idle_cycle();

        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            if (i % 37 == 0) set_csm(4'($urandom));
            d = 8'($urandom);
            if (i % 5 == 0) d[7:4] = g_m[4*((d[2:0] > 3'd3) ? int'(d[2:0]) - 1 : int'(d[2:0]) % 6) +: 4];
            do_write(d, tag_for(d));
            if ($urandom % 4 == 0) idle_cycle();
        end
        idle_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule